// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block derives a card clock from a source clock. The clock can run at the source rate (bypass) or at the source rate divided by an even number. It can be gated off entirely. It can also be allowed to stop while the card reports idle, which saves power.

Software stages three settings: an enable, a low-power permission and a divider value. Writing them has no effect by itself. The staged values move into the active set only after an update request. The update raises a busy flag that stays up until the new values have been taken.

The block takes the new values only while the divided clock is low. A divider change therefore never produces a shortened pulse. The usual sequence is:

1. Disable the clock and update.
2. Change the divider and update.
3. Enable the clock again and update.

Top module: `card_clk_div`

## Requirements
- R1: After reset the active settings are disabled. `startBusy` is 0, `cardClk` is low and shows no rising edge until an update enables it.
- R2: An active divider value of 0 selects bypass: `cardClk` has the same period as `clk`.
- R3: An active divider value N (1 to 2^DIV_W-1) gives a `cardClk` period of exactly 2N source cycles, with N cycles high and N cycles low.
- R4: With the active enable bit at 0, `cardClk` stays low and makes no edges.
- R5: With the active low-power bit at 1, `cardClk` stops low while `cardIdle` is 1 and resumes when it returns to 0. With the low-power bit at 0, `cardIdle` has no effect.
- R6: Changes on `cfgEnable`, `cfgLowPower` or `cfgDivider` have no effect on `cardClk` until an update request is accepted.
- R7: A one-cycle `updateReq` while idle sets `startBusy` from the next cycle. The staged settings are latched at the first clock edge on which the divided clock is low. `startBusy` clears exactly ACK_CYCLES cycles after that latch. While the clock is stopped low, busy therefore lasts 1+ACK_CYCLES cycles.
- R8: `updateReq` asserted while `startBusy` is 1 is ignored. It neither lengthens the busy period nor starts a second update.
- R9: A switch between settings never produces a `cardClk` pulse shorter than the shorter half-period of the old and new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Staged clock enable |
| cfgLowPower | input | 1 | Staged permission to stop the clock while the card is idle |
| cfgDivider | input | DIV_W | Staged divider value (0 = bypass) |
| updateReq | input | 1 | Request to take the staged settings (start bit set) |
| cardIdle | input | 1 | Card is idle; used only when low power is active |
| startBusy | output | 1 | Start bit: high until the staged settings have been latched and acknowledged |
| cardClk | output | 1 | Generated card clock |

## Verification
A wrong divider count shows up as a wrong `cardClk` period within two card-clock periods of the update completing. A latch taken while the clock is high shows up as a pulse narrower than either half-period, seen at the first edge after the switch. An update handshake that is stuck or restarted changes the length of the busy window, which is visible cycle by cycle on `startBusy` under a stopped clock. A broken stop condition shows up as rising edges during a window in which the clock should be held low.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } updState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // take staged settings into the active set
    logic restart;  // phase counter restarts with the new settings
  } cdivStrobe_t;

endpackage

// File: rtl/cdiv_gate.sv
// Enable captured on the falling source edge, so the gated clock
// can only switch while the source is low.
module cdiv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic enQ;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) enQ <= 1'b0;
    else        enQ <= en;
  end

  assign gclk = clk & enQ;
endmodule

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int ACK_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        updateReq,
  input  logic        lowPhase,
  output cdivStrobe_t strb,
  output logic        startBusy
);
  localparam int ACK_W = (ACK_CYCLES < 2) ? 1 : $clog2(ACK_CYCLES);

  updState_t       state, stateNext;
  logic [ACK_W-1:0] ackCnt;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (updateReq) stateNext = ST_WAIT;
      ST_WAIT: if (lowPhase) begin
        strb.latch   = 1'b1;
        strb.restart = 1'b1;
        stateNext    = ST_ACK;
      end
      ST_ACK:  if (ackCnt == '0) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ackCnt <= '0;
    end else begin
      state <= stateNext;
      if (strb.latch)             ackCnt <= ACK_W'(ACK_CYCLES - 1);
      else if (ackCnt != '0)      ackCnt <= ackCnt - 1'b1;
    end
  end

  assign startBusy = (state != ST_IDLE);
endmodule

// File: rtl/cdiv_datapath.sv
module cdiv_datapath
  import cdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cdivStrobe_t      strb,
  input  logic             cfgEnable,
  input  logic             cfgLowPower,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic             cardIdle,
  output logic             divOut,
  output logic             bypassRun,
  output logic             lowPhase,
  output logic             runEn,
  output logic             actEnable,
  output logic [DIV_W-1:0] actDivider
);
  logic             actLowPower;
  logic [DIV_W-1:0] phaseCnt;
  logic             bypassSel;
  logic             phaseEnd;

  assign bypassSel = (actDivider == '0);
  assign runEn     = actEnable & ~(actLowPower & cardIdle);
  assign phaseEnd  = (phaseCnt == actDivider - DIV_W'(1));
  assign bypassRun = bypassSel & runEn;
  assign lowPhase  = ~divOut;

  // active settings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actEnable   <= 1'b0;
      actLowPower <= 1'b0;
      actDivider  <= '0;
    end else if (strb.latch) begin
      actEnable   <= cfgEnable;
      actLowPower <= cfgLowPower;
      actDivider  <= cfgDivider;
    end
  end

  // half-period counter and divided output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
      divOut   <= 1'b0;
    end else if (strb.restart) begin
      phaseCnt <= '0;
      divOut   <= 1'b0;
    end else if (bypassSel) begin
      phaseCnt <= '0;
      divOut   <= 1'b0;
    end else if (!runEn && !divOut) begin
      phaseCnt <= '0;                 // parked low
    end else if (phaseEnd) begin
      phaseCnt <= '0;
      divOut   <= ~divOut;
    end else begin
      phaseCnt <= phaseCnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import cdiv_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int ACK_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgEnable,
  input  logic             cfgLowPower,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic             updateReq,
  input  logic             cardIdle,
  output logic             startBusy,
  output logic             cardClk
);
  cdivStrobe_t      strb;
  logic             divOut;
  logic             bypassRun;
  logic             lowPhase;
  logic             runEn;
  logic             actEnable;
  logic [DIV_W-1:0] actDivider;
  logic             bypassClk;

  cdiv_ctrl #(.ACK_CYCLES(ACK_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .updateReq(updateReq), .lowPhase(lowPhase),
    .strb(strb), .startBusy(startBusy)
  );

  cdiv_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .cfgEnable(cfgEnable), .cfgLowPower(cfgLowPower), .cfgDivider(cfgDivider),
    .cardIdle(cardIdle), .divOut(divOut), .bypassRun(bypassRun),
    .lowPhase(lowPhase), .runEn(runEn), .actEnable(actEnable),
    .actDivider(actDivider)
  );

  cdiv_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(bypassRun), .gclk(bypassClk)
  );

  assign cardClk = divOut | bypassClk;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
  parameter int DIV_W      = 8,
  parameter int ACK_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             updateReq,
  input logic             startBusy,
  input logic             divOut,
  input logic             runEn,
  input logic             actEnable,
  input logic [DIV_W-1:0] actDivider
);
  localparam int BUSY_MAX = (1 << DIV_W) + ACK_CYCLES + 2;

  logic [31:0] busyLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busyLen <= '0;
    else if (startBusy) busyLen <= busyLen + 32'd1;
    else                busyLen <= '0;
  end

  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startBusy) |-> $past(updateReq));

  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busyLen <= BUSY_MAX);

  assert_change_in_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(actDivider) |-> $past(startBusy));

  assert_switch_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(actDivider) |-> !$past(divOut));

  assert_parked_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!runEn && !divOut) |=> !divOut);

  assert_disabled_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !actEnable |-> !divOut);
endmodule

bind card_clk_div card_clk_div_chk #(.DIV_W(DIV_W), .ACK_CYCLES(ACK_CYCLES)) u_chk (.*);

// File: tb/sim_card_clk_div.sv
`timescale 1ns/1ps
module sim_card_clk_div;
  localparam int PERIOD = 10;
  localparam int DW     = 8;
  localparam int ACK    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfgEnable = 1'b0;
  logic          cfgLowPower = 1'b0;
  logic [DW-1:0] cfgDivider = '0;
  logic          updateReq = 1'b0;
  logic          cardIdle = 1'b0;
  logic          startBusy;
  logic          cardClk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  card_clk_div #(.DIV_W(DW), .ACK_CYCLES(ACK)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgEnable(cfgEnable), .cfgLowPower(cfgLowPower),
    .cfgDivider(cfgDivider), .updateReq(updateReq), .cardIdle(cardIdle),
    .startBusy(startBusy), .cardClk(cardClk)
  );

  always #(PERIOD/2) clk = ~clk;

  // card clock observation
  longint lastRise = 0, prevRise = 0, lastEdge = 0, minWidth = 0;
  int     riseCnt = 0;
  bit     trackWidth = 1'b0;

  always @(posedge cardClk) begin
    prevRise = lastRise;
    lastRise = $time;
    riseCnt++;
  end

  always @(cardClk) begin
    longint w;
    w = $time - lastEdge;
    if (trackWidth && w > 0 && (minWidth == 0 || w < minWidth)) minWidth = w;
    lastEdge = $time;
  end

  function automatic longint expPeriod(input int div);
    return (div == 0) ? longint'(PERIOD) : longint'(2 * div * PERIOD);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyCfg(input bit en, input bit lp, input int div, input int reqLen,
                          output int busy);
    @(negedge clk);
    cfgEnable   = en;
    cfgLowPower = lp;
    cfgDivider  = DW'(div);
    updateReq   = 1'b1;
    busy = 0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (n + 1 >= reqLen) updateReq = 1'b0;
      if (startBusy) busy++;
      else break;
    end
  endtask

  task automatic measure(input int div, output longint per, output int rises);
    int r0;
    r0 = riseCnt;
    repeat (4 * (2 * div + 1) + 4) @(negedge clk);
    per   = lastRise - prevRise;
    rises = riseCnt - r0;
  endtask

  task automatic quietWindow(input int cyc, output int rises, output bit sawHigh);
    int r0;
    r0 = riseCnt;
    sawHigh = 1'b0;
    repeat (cyc) begin
      @(negedge clk);
      if (cardClk) sawHigh = 1'b1;
    end
    rises = riseCnt - r0;
  endtask

  initial begin
    #(longint'(PERIOD) * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int     busy, rises;
    longint per;
    bit     hi;
    int     d;
    int     r;

    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(startBusy == 1'b0, "R1 busy", startBusy, 0);
    quietWindow(20, rises, hi);
    check(rises == 0 && !hi, "R1 quiet", rises, 0);

    // R7: busy length with clock stopped
    applyCfg(1'b0, 1'b0, 3, 1, busy);
    check(busy == 1 + ACK, "R7 busy length", busy, 1 + ACK);

    // R8: request held while busy is ignored
    applyCfg(1'b0, 1'b0, 3, 2, busy);
    check(busy == 1 + ACK, "R8 busy not extended", busy, 1 + ACK);

    // R2: bypass
    applyCfg(1'b1, 1'b0, 0, 1, busy);
    measure(0, per, rises);
    check(per == expPeriod(0) && rises >= 2, "R2 bypass period", per, expPeriod(0));

    // R3: divide by 2N
    applyCfg(1'b1, 1'b0, 3, 1, busy);
    measure(3, per, rises);
    check(per == expPeriod(3), "R3 period N=3", per, expPeriod(3));

    // R6: staged change without update has no effect
    @(negedge clk);
    cfgDivider = DW'(7);
    cfgEnable  = 1'b0;
    measure(7, per, rises);
    check(per == expPeriod(3) && rises >= 2, "R6 no effect", per, expPeriod(3));

    // R9: divider switch 3 -> 5 free of runts
    minWidth = 0; trackWidth = 1'b1;
    applyCfg(1'b1, 1'b0, 5, 1, busy);
    measure(5, per, rises);
    check(minWidth >= 3 * PERIOD, "R9 min width 3->5", minWidth, 3 * PERIOD);
    check(per == expPeriod(5), "R3 period N=5", per, expPeriod(5));

    // R9: divided -> bypass -> divided
    applyCfg(1'b1, 1'b0, 0, 1, busy);
    measure(0, per, rises);
    applyCfg(1'b1, 1'b0, 2, 1, busy);
    measure(2, per, rises);
    check(minWidth >= PERIOD / 2, "R9 min width bypass switch", minWidth, PERIOD / 2);
    check(per == expPeriod(2), "R3 period N=2 after bypass", per, expPeriod(2));
    trackWidth = 1'b0;

    // R4: disabled clock stays low
    applyCfg(1'b0, 1'b0, 2, 1, busy);
    quietWindow(30, rises, hi);
    check(rises == 0 && !hi, "R4 disabled", rises, 0);

    // R5: low power stop while idle, resume when busy
    @(negedge clk); cardIdle = 1'b1;
    applyCfg(1'b1, 1'b1, 2, 1, busy);
    quietWindow(30, rises, hi);
    check(rises == 0 && !hi, "R5 idle stop", rises, 0);
    @(negedge clk); cardIdle = 1'b0;
    measure(2, per, rises);
    check(per == expPeriod(2) && rises >= 2, "R5 resume", per, expPeriod(2));
    @(negedge clk); cardIdle = 1'b1;
    applyCfg(1'b1, 1'b0, 0, 1, busy);
    measure(0, per, rises);
    check(per == expPeriod(0) && rises >= 2, "R5 idle ignored without low power", per, expPeriod(0));
    applyCfg(1'b1, 1'b1, 0, 1, busy);
    quietWindow(20, rises, hi);
    check(rises == 0 && !hi, "R5 bypass idle stop", rises, 0);
    @(negedge clk); cardIdle = 1'b0;

    // random settings, R3/R2/R9
    for (int i = 0; i < 12; i++) begin
      d = int'($urandom_range(0, 9));
      r = int'($urandom_range(0, 1));
      minWidth = 0; trackWidth = 1'b1;
      applyCfg(1'b1, r[0], d, 1, busy);
      measure(d, per, rises);
      trackWidth = 1'b0;
      check(per == expPeriod(d) && rises >= 2, "R3 random period", per, expPeriod(d));
      check(minWidth >= PERIOD / 2, "R9 random min width", minWidth, PERIOD / 2);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule